// File: doc/BRIEF.md
# Console Device Register Page

This block sits on a 16-bit processor memory bus and owns the top page of the address space, from 0xFE00 upward. Within that page it implements three devices: a keyboard input port, a display output port and a machine control word. Every access below the page is handed unchanged to ordinary memory through separate strobes. Reads from the page return register contents, and writes to the page never reach memory.

Keyboard characters arrive as a one-cycle valid pulse with an 8-bit code. Display characters leave through a valid/ready handshake. Each device has a status word. Bit 15 of a status word is a hardware flag: ready for the keyboard, done for the display. Bit 14 is an interrupt enable that software writes. A device raises its own interrupt request while its flag and its enable are both set. Bit 15 of the control word is a run latch. It drives a run output that the surrounding system uses to gate the processor clock, so clearing the latch halts the machine.

Top module: `console_mmio`

## Requirements
- R1: After reset, runEn is 1, the display done flag is 1, the keyboard ready flag is 0, both interrupt enables are 0, dispValid is 0 and both interrupt outputs are 0. Reading 0xFE04 returns 0x8000, reading 0xFFFE returns 0x8000 and reading 0xFE00 returns 0x0000.
- R2: An access to an address below 0xFE00 asserts memRead or memWrite in the same cycle, and busRdata equals memRdata. An access at 0xFE00 or above asserts neither memory strobe.
- R3: The keyboard status word at 0xFE00 reads ready in bit 15, enable in bit 14 and zero in all other bits. A write changes only the enable, which takes the value of written bit 14.
- R4: A kbdValid pulse sets the ready flag and stores kbdData. Reading 0xFE02 returns the stored code in bits 7..0 with zero above. A later character overwrites an earlier one that was not read.
- R5: A read of 0xFE02 clears the ready flag from the next cycle. If a character arrives in the same cycle as that read, the new character is stored and ready stays set.
- R6: The display status word at 0xFE04 reads done in bit 15, enable in bit 14 and zero in all other bits. A write changes only the enable.
- R7: A write to 0xFE06 raises dispValid with dispData equal to written bits 7..0 from the next cycle, and clears done. dispValid and dispData hold steady until a cycle with dispReady high. After that cycle dispValid is 0 and done is 1.
- R8: The control word at 0xFFFE reads the run latch in bit 15 and zero elsewhere. A write loads the latch from written bit 15, and runEn follows the latch from the next cycle.
- R9: kbdIrq is 1 exactly when keyboard ready and keyboard enable are both set. dispIrq is 1 exactly when display done and display enable are both set.
- R10: Any address in the page other than the five register addresses (including odd neighbours) reads as zero, and writes to it change no register. Reading 0xFE06 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bus address |
| busRead | input | 1 | Read strobe |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (register or memory) |
| memRead | output | 1 | Read strobe passed to memory |
| memWrite | output | 1 | Write strobe passed to memory |
| memRdata | input | 16 | Memory read data |
| kbdValid | input | 1 | New keyboard character present |
| kbdData | input | 8 | Keyboard character code |
| dispValid | output | 1 | Display character offered |
| dispData | output | 8 | Display character code |
| dispReady | input | 1 | Display sink accepts the character |
| runEn | output | 1 | Run latch, gates the processor clock |
| kbdIrq | output | 1 | Keyboard interrupt request |
| dispIrq | output | 1 | Display interrupt request |

## Verification
The bench covers the edge of the page at 0xFDFF and 0xFE00. A decoder that is off by one there would either strobe memory for a register access or hide memory behind a zero. It also covers a keyboard character that lands in the same cycle as a data read. A design that gave the read priority would drop that character's ready flag, so the character would be lost. The display is held busy for several cycles with writes to its status word in the meantime. A design that let software set done, or that released dispValid early, would show up through a changed status word or a lost character. Writes to unmapped page addresses and to the flag bits are followed by read-backs of every register, which exposes any decoder that aliases addresses.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_KSTAT,
    SEL_KCHAR,
    SEL_DSTAT,
    SEL_CTRL,
    SEL_MEM
  } rdSel_e;

  typedef struct packed {
    logic   kStatWr;
    logic   kCharRd;
    logic   dStatWr;
    logic   dCharWr;
    logic   ctrlWr;
    rdSel_e rdSel;
  } ioStrb_t;

endpackage

// File: rtl/console_mmio_ctrl.sv
module console_mmio_ctrl
  import console_mmio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
  parameter logic [ADDR_W-1:0] KCHAR_A = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
  parameter logic [ADDR_W-1:0] DCHAR_A = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_A  = 16'hFFFE
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output ioStrb_t           strb,
  output logic              memRead,
  output logic              memWrite
);

  logic ioPage;
  assign ioPage   = (busAddr >= IO_BASE);
  assign memRead  = busRead  && !ioPage;
  assign memWrite = busWrite && !ioPage;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_ZERO;
    if (!ioPage) begin
      strb.rdSel = SEL_MEM;
    end else begin
      unique case (busAddr)
        KSTAT_A: begin strb.rdSel = SEL_KSTAT; strb.kStatWr = busWrite; end
        KCHAR_A: begin strb.rdSel = SEL_KCHAR; strb.kCharRd = busRead;  end
        DSTAT_A: begin strb.rdSel = SEL_DSTAT; strb.dStatWr = busWrite; end
        DCHAR_A: begin strb.dCharWr = busWrite; end
        CTRL_A:  begin strb.rdSel = SEL_CTRL;  strb.ctrlWr  = busWrite; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/console_mmio_dp.sv
module console_mmio_dp
  import console_mmio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrb_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              kbdValid,
  input  logic [CHAR_W-1:0] kbdData,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispData,
  input  logic              dispReady,
  output logic              runEn,
  output logic              kbdIrq,
  output logic              dispIrq
);

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int IE_BIT   = DATA_W - 2;

  logic              kbdReady, kbdIe, dispBusy, dispIe, runLatch;
  logic [CHAR_W-1:0] kbdChar, dispChar;
  logic              dispDone;

  assign dispDone = !dispBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdReady <= 1'b0;
      kbdIe    <= 1'b0;
      kbdChar  <= '0;
      dispBusy <= 1'b0;
      dispIe   <= 1'b0;
      dispChar <= '0;
      runLatch <= 1'b1;
    end else begin
      // a fresh character beats a concurrent data read
      if (strb.kCharRd) kbdReady <= 1'b0;
      if (kbdValid) begin
        kbdReady <= 1'b1;
        kbdChar  <= kbdData;
      end
      if (strb.kStatWr) kbdIe  <= busWdata[IE_BIT];
      if (strb.dStatWr) dispIe <= busWdata[IE_BIT];
      if (dispBusy && dispReady) dispBusy <= 1'b0;
      if (strb.dCharWr) begin
        dispBusy <= 1'b1;
        dispChar <= busWdata[CHAR_W-1:0];
      end
      if (strb.ctrlWr) runLatch <= busWdata[FLAG_BIT];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strb.rdSel)
      SEL_KSTAT: begin busRdata[FLAG_BIT] = kbdReady; busRdata[IE_BIT] = kbdIe; end
      SEL_KCHAR: busRdata[CHAR_W-1:0] = kbdChar;
      SEL_DSTAT: begin busRdata[FLAG_BIT] = dispDone; busRdata[IE_BIT] = dispIe; end
      SEL_CTRL:  busRdata[FLAG_BIT] = runLatch;
      SEL_MEM:   busRdata = memRdata;
      default:   busRdata = '0;
    endcase
  end

  assign dispValid = dispBusy;
  assign dispData  = dispChar;
  assign runEn     = runLatch;
  assign kbdIrq    = kbdReady && kbdIe;
  assign dispIrq   = dispDone && dispIe;

endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_mmio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
  parameter logic [ADDR_W-1:0] KCHAR_A = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
  parameter logic [ADDR_W-1:0] DCHAR_A = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_A  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              memRead,
  output logic              memWrite,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              kbdValid,
  input  logic [CHAR_W-1:0] kbdData,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispData,
  input  logic              dispReady,
  output logic              runEn,
  output logic              kbdIrq,
  output logic              dispIrq
);

  ioStrb_t strb;

  console_mmio_ctrl #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .KSTAT_A(KSTAT_A), .KCHAR_A(KCHAR_A),
    .DSTAT_A(DSTAT_A), .DCHAR_A(DCHAR_A), .CTRL_A(CTRL_A)
  ) uCtrl (
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .strb(strb), .memRead(memRead), .memWrite(memWrite)
  );

  console_mmio_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .memRdata(memRdata),
    .kbdValid(kbdValid), .kbdData(kbdData),
    .dispValid(dispValid), .dispData(dispData), .dispReady(dispReady),
    .runEn(runEn), .kbdIrq(kbdIrq), .dispIrq(dispIrq)
  );

endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
  parameter logic [ADDR_W-1:0] KCHAR_A = 16'hFE02,
  parameter logic [ADDR_W-1:0] DCHAR_A = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_A  = 16'hFFFE
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              busWrite,
  input logic [DATA_W-1:0] busWdata,
  input logic              memRead,
  input logic              memWrite,
  input logic              kbdValid,
  input logic              dispValid,
  input logic [CHAR_W-1:0] dispData,
  input logic              dispReady,
  input logic              runEn,
  input logic              kbdIrq,
  input logic              dispIrq
);

  a_r2_page_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= IO_BASE) |-> (!memRead && !memWrite));

  a_r7_offer_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady && !(busWrite && busAddr == DCHAR_A))
      |=> (dispValid && $stable(dispData)));

  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    dispIrq |-> !dispValid);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == KCHAR_A && !kbdValid) |=> !kbdIrq);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kbdIrq) |-> $past(kbdValid || (busWrite && busAddr == KSTAT_A)));

  a_r8_run_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == CTRL_A) |=> (runEn == $past(busWdata[DATA_W-1])));

endmodule

bind console_mmio console_mmio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .IO_BASE(IO_BASE),
  .KSTAT_A(KSTAT_A), .KCHAR_A(KCHAR_A), .DCHAR_A(DCHAR_A), .CTRL_A(CTRL_A)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
  .busWrite(busWrite), .busWdata(busWdata), .memRead(memRead),
  .memWrite(memWrite), .kbdValid(kbdValid), .dispValid(dispValid),
  .dispData(dispData), .dispReady(dispReady), .runEn(runEn),
  .kbdIrq(kbdIrq), .dispIrq(dispIrq)
);

// File: tb/console_mmio_test.sv
module console_mmio_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        memRead, memWrite;
  logic [15:0] memRdata = 16'hBEEF;
  logic        kbdValid = 1'b0;
  logic [7:0]  kbdData = '0;
  logic        dispValid;
  logic [7:0]  dispData;
  logic        dispReady = 1'b0;
  logic        runEn, kbdIrq, dispIrq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  console_mmio uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .memRead(memRead), .memWrite(memWrite), .memRdata(memRdata),
    .kbdValid(kbdValid), .kbdData(kbdData), .dispValid(dispValid),
    .dispData(dispData), .dispReady(dispReady), .runEn(runEn),
    .kbdIrq(kbdIrq), .dispIrq(dispIrq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive a one-cycle write starting at a falling edge
  task automatic busWr(input logic [15:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [15:0] a, output logic [15:0] d);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic kbdPush(input logic [7:0] c);
    kbdData = c; kbdValid = 1'b1;
    @(negedge clk);
    kbdValid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 runEn", {15'd0, runEn}, 16'd1);
    check("R1 dispValid", {15'd0, dispValid}, 16'd0);
    check("R1 irqs", {14'd0, kbdIrq, dispIrq}, 16'd0);
    busRd(16'hFE00, d); check("R1 kbd status", d, 16'h0000);
    busRd(16'hFE04, d); check("R1 disp status", d, 16'h8000);
    busRd(16'hFFFE, d); check("R1 control", d, 16'h8000);
  endtask

  task automatic t_memory;
    logic [15:0] d;
    busAddr = 16'h3000; busRead = 1'b1; #1;
    check("R2 memRead low", {15'd0, memRead}, 16'd1);
    check("R2 rdata from mem", busRdata, 16'hBEEF);
    @(negedge clk); busRead = 1'b0;
    busAddr = 16'hFDFF; busWrite = 1'b1; #1;
    check("R2 memWrite FDFF", {15'd0, memWrite}, 16'd1);
    @(negedge clk); busWrite = 1'b0;
    busAddr = 16'hFE00; busRead = 1'b1; busWrite = 1'b0; #1;
    check("R2 no memRead FE00", {15'd0, memRead}, 16'd0);
    @(negedge clk); busRead = 1'b0;
    busAddr = 16'hFFFE; busWrite = 1'b1; busWdata = 16'h8000; #1;
    check("R2 no memWrite page", {15'd0, memWrite}, 16'd0);
    @(negedge clk); busWrite = 1'b0;
    busRd(16'h0000, d); check("R2 addr 0 mem", d, 16'hBEEF);
  endtask

  task automatic t_keyboard;
    logic [15:0] d;
    kbdPush(8'h41);
    busRd(16'hFE00, d); check("R4 ready set", d, 16'h8000);
    kbdPush(8'h42);
    busRd(16'hFE02, d); check("R4 overwrite char", d, 16'h0042);
    busRd(16'hFE00, d); check("R5 read clears ready", d, 16'h0000);
    busRd(16'hFE02, d); check("R4 char retained", d, 16'h0042);
    // character arriving with the read
    kbdPush(8'h10);
    kbdData = 8'h7E; kbdValid = 1'b1;
    busRd(16'hFE02, d);
    kbdValid = 1'b0;
    check("R5 race old char read", d, 16'h0010);
    busRd(16'hFE00, d); check("R5 race keeps ready", d, 16'h8000);
    busRd(16'hFE02, d); check("R5 race new char", d, 16'h007E);
  endtask

  task automatic t_kbdStatus;
    logic [15:0] d;
    busWr(16'hFE00, 16'hFFFF);
    busRd(16'hFE00, d); check("R3 only enable writable", d, 16'h4000);
    check("R9 kbd irq off", {15'd0, kbdIrq}, 16'd0);
    kbdPush(8'h55);
    check("R9 kbd irq on", {15'd0, kbdIrq}, 16'd1);
    busWr(16'hFE00, 16'hBFFF);
    check("R9 irq off when disabled", {15'd0, kbdIrq}, 16'd0);
    busRd(16'hFE00, d); check("R3 enable cleared", d, 16'h8000);
    busWr(16'hFE00, 16'h4000);
    check("R9 irq back", {15'd0, kbdIrq}, 16'd1);
    busRd(16'hFE02, d);
    check("R9 irq drops after read", {15'd0, kbdIrq}, 16'd0);
    busWr(16'hFE00, 16'h0000);
  endtask

  task automatic t_display;
    logic [15:0] d;
    busWr(16'hFE04, 16'h4000);
    check("R9 disp irq done", {15'd0, dispIrq}, 16'd1);
    busWr(16'hFE06, 16'h1F5A);
    check("R7 valid raised", {15'd0, dispValid}, 16'd1);
    check("R7 data", {8'd0, dispData}, 16'h005A);
    check("R9 disp irq busy", {15'd0, dispIrq}, 16'd0);
    busWr(16'hFE04, 16'hC000);
    busRd(16'hFE04, d); check("R6 done not writable", d, 16'h4000);
    repeat (3) @(negedge clk);
    check("R7 held", {7'd0, dispValid, dispData}, 16'h015A);
    busRd(16'hFE06, d); check("R10 display data reads zero", d, 16'h0000);
    dispReady = 1'b1;
    @(negedge clk);
    dispReady = 1'b0;
    check("R7 valid dropped", {15'd0, dispValid}, 16'd0);
    busRd(16'hFE04, d); check("R7 done again", d, 16'hC000);
    busWr(16'hFE04, 16'h8000);
    busRd(16'hFE04, d); check("R6 enable cleared", d, 16'h8000);
    check("R9 disp irq off", {15'd0, dispIrq}, 16'd0);
  endtask

  task automatic t_control;
    logic [15:0] d;
    busWr(16'hFFFE, 16'h7FFF);
    check("R8 run cleared", {15'd0, runEn}, 16'd0);
    busRd(16'hFFFE, d); check("R8 read halted", d, 16'h0000);
    busWr(16'hFFFE, 16'hFFFF);
    check("R8 run set", {15'd0, runEn}, 16'd1);
    busRd(16'hFFFE, d); check("R8 reserved zero", d, 16'h8000);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    busWr(16'hFE08, 16'hFFFF);
    busWr(16'hFE01, 16'h0000);
    busWr(16'hFFFF, 16'h0000);
    busWr(16'hFE05, 16'hFFFF);
    busRd(16'hFE08, d); check("R10 FE08 zero", d, 16'h0000);
    busRd(16'hFE01, d); check("R10 FE01 zero", d, 16'h0000);
    busRd(16'hFFFC, d); check("R10 FFFC zero", d, 16'h0000);
    busRd(16'hFE00, d); check("R10 kbd status kept", d, 16'h0000);
    busRd(16'hFE04, d); check("R10 disp status kept", d, 16'h8000);
    busRd(16'hFFFE, d); check("R10 control kept", d, 16'h8000);
    check("R10 no display start", {15'd0, dispValid}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_memory();
    t_keyboard();
    t_kbdStatus();
    t_display();
    t_control();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule